// File: doc/BRIEF.md
# Burst CRC Checker with First-Error Latch

This block sits on the device side of a 16-bit DMA data path that moves data in bursts. It runs a CRC over every data word taken in during a burst, starting again from a fixed seed each time a burst opens. When the burst closes, the sender supplies its own CRC value. The block compares that value with its own result. A mismatch raises an error bit, and the bit stays set for the rest of the command.

Within one command the block counts bursts. It keeps the index of the first burst that failed, so later failures never overwrite what was reported first. A policy input decides what happens on the first failure. With the policy off, the transfer carries on until the command completes normally. With it on, the command is aborted at once. In both cases the completion interrupt is pulsed and the error remains readable.

Data words arrive on a valid/ready stream. The block never stalls a word on its own account. It asserts ready exactly when a burst is open and the burst is not being closed in that same cycle. A word offered while ready is low is dropped, so the sender must hold it. Everything else on the interface is a plain level or a one-cycle pulse.

Top module: `burst_crc_checker`

## Requirements
- R1: After reset, `word_ready`, `crc_err`, `cmd_busy`, `cmd_aborted` and `done_irq` are 0, and `err_burst` and `burst_num` are 0.
- R2: `word_ready` is 1 only while a burst is open and `burst_end` is low. A word is consumed only when `word_valid` and `word_ready` are both 1. A word offered in the opening cycle or in the closing cycle has no effect on the CRC.
- R3: The CRC is 16 bits wide with polynomial x^16+x^12+x^5+1 (0x1021). It is loaded with 0x4ABA on every `burst_start`. Each consumed 16-bit word is folded in MSB first, one word per cycle.
- R4: `burst_end` while a burst is open closes the burst and compares `host_crc` with the CRC of the words consumed so far. On a difference, `crc_err` is 1 from the next cycle.
- R5: Once set, `crc_err` stays 1 until the next `cmd_start`. `err_burst` holds the index of the first failing burst, and later failing or passing bursts leave both unchanged.
- R6: `burst_num` counts the bursts closed since `cmd_start`, starting at 0. The first burst of a command has index 0.
- R7: If `abort_on_err` is 1 when the first error of a busy command is detected, then in the next cycle `cmd_aborted` becomes 1, `cmd_busy` becomes 0 and `done_irq` pulses. If `abort_on_err` is 0, an error does not end the command.
- R8: `done_irq` is a one-cycle pulse in the cycle after `cmd_done` while `cmd_busy` is 1. A `cmd_done` while the block is not busy produces no pulse.
- R9: `cmd_start` clears `crc_err`, `err_burst`, `burst_num` and `cmd_aborted` and sets `cmd_busy`, all effective in the next cycle.
- R10: A `burst_end` while no burst is open changes neither `burst_num` nor `crc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Pulse: a new command begins |
| cmd_done | input | 1 | Pulse: the command finished its data |
| abort_on_err | input | 1 | 1 = abort the command on the first CRC error |
| burst_start | input | 1 | Pulse: open a burst and reseed the CRC |
| burst_end | input | 1 | Pulse: close the burst, host_crc valid |
| host_crc | input | 16 | CRC value sent by the host at burst close |
| word_valid | input | 1 | Data word offered |
| word_ready | output | 1 | Data word accepted this cycle if valid |
| word_data | input | 16 | Data word |
| crc_err | output | 1 | Sticky CRC error for the current command |
| err_burst | output | 8 | Index of the first failing burst |
| burst_num | output | 8 | Bursts closed in this command |
| cmd_busy | output | 1 | Command in progress |
| cmd_aborted | output | 1 | Command ended by the abort policy |
| done_irq | output | 1 | One-cycle completion interrupt |

## Verification
The hardest situation to reach is a command in which a good burst is followed by two failing bursts and then another good one. That sequence shows the latch keeping the first index while the CRC keeps reseeding. The bench builds such commands from a burst task that chooses, per burst, whether to corrupt the host CRC. That task also offers stray words in the opening and closing cycles, when ready is low. It also injects `burst_end` and `cmd_done` pulses while idle. A behavioural model tracks every output on each clock, so any slip in first-error ordering or in the abort policy shows up in the cycle where it happens.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int          WORD_W   = 16;
  localparam int          IDX_W    = 8;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'h4ABA;

  typedef struct packed {
    logic             ev;
    logic             mismatch;
  } burst_close_t;
endpackage

// File: rtl/bcc_crc_acc.sv
module bcc_crc_acc #(
  parameter int              DW   = 16,
  parameter logic [DW-1:0]   POLY = 16'h1021,
  parameter logic [DW-1:0]   SEED = 16'h4ABA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_i,
  input  logic          close_i,
  input  logic          wvalid_i,
  input  logic [DW-1:0] wdata_i,
  output logic          wready_o,
  output logic          active_o,
  output logic [DW-1:0] crc_o
);
  logic          active_q;
  logic [DW-1:0] crc_q;
  logic [DW-1:0] crc_nx;
  logic          take;

  function automatic logic [DW-1:0] fold(input logic [DW-1:0] c, input logic [DW-1:0] d);
    logic [DW-1:0] r;
    logic          fb;
    r = c;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = r[DW-1] ^ d[i];
      r  = {r[DW-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return r;
  endfunction

  assign wready_o = active_q & ~close_i;
  assign take     = wvalid_i & wready_o;
  assign crc_nx   = fold(crc_q, wdata_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      crc_q    <= SEED;
    end else begin
      if (open_i)                  active_q <= 1'b1;
      else if (close_i && active_q) active_q <= 1'b0;
      if (open_i)    crc_q <= SEED;
      else if (take) crc_q <= crc_nx;
    end
  end

  assign active_o = active_q;
  assign crc_o    = crc_q;

  p_seed_on_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    open_i |=> (crc_q == SEED));
  p_hold_without_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !open_i) |=> $stable(crc_q));
  p_close_shuts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (close_i && !open_i) |=> !wready_o);
endmodule

// File: rtl/bcc_err_latch.sv
module bcc_err_latch #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  bcc_pkg::burst_close_t close_i,
  output logic             first_err_o,
  output logic             err_o,
  output logic [CNT_W-1:0] idx_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             err_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;

  assign first_err_o = close_i.ev & close_i.mismatch & ~err_q & ~clear_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      err_q <= 1'b0;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (close_i.ev) begin
      cnt_q <= cnt_q + 1'b1;
      if (first_err_o) begin
        err_q <= 1'b1;
        idx_q <= cnt_q;
      end
    end
  end

  assign err_o = err_q;
  assign idx_o = idx_q;
  assign cnt_o = cnt_q;

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clear_i) |=> err_q);
  p_idx_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clear_i) |=> $stable(idx_q));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!err_q && cnt_q == '0));
  p_mismatch_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (close_i.ev && close_i.mismatch && !clear_i) |=> err_q);
endmodule

// File: rtl/bcc_cmd_ctl.sv
module bcc_cmd_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  input  logic abort_en_i,
  input  logic first_err_i,
  output logic busy_o,
  output logic aborted_o,
  output logic irq_o
);
  logic busy_q, aborted_q, irq_q;
  logic abort_ev, finish_ev;

  assign abort_ev  = busy_q & first_err_i & abort_en_i & ~start_i;
  assign finish_ev = busy_q & (done_i | abort_ev) & ~start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      aborted_q <= 1'b0;
      irq_q     <= 1'b0;
    end else if (start_i) begin
      busy_q    <= 1'b1;
      aborted_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= finish_ev;
      if (finish_ev) busy_q    <= 1'b0;
      if (abort_ev)  aborted_q <= 1'b1;
    end
  end

  assign busy_o    = busy_q;
  assign aborted_o = aborted_q;
  assign irq_o     = irq_q;

  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  p_no_irq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_i) |=> !irq_q);
  p_abort_policy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && first_err_i && abort_en_i && !start_i) |=> (aborted_q && !busy_q && irq_q));
  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_q && !aborted_q));
endmodule

// File: rtl/burst_crc_checker.sv
module burst_crc_checker #(
  parameter int                        DW    = bcc_pkg::WORD_W,
  parameter int                        CNT_W = bcc_pkg::IDX_W,
  parameter logic [bcc_pkg::WORD_W-1:0] POLY = bcc_pkg::CRC_POLY,
  parameter logic [bcc_pkg::WORD_W-1:0] SEED = bcc_pkg::CRC_SEED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_done,
  input  logic             abort_on_err,
  input  logic             burst_start,
  input  logic             burst_end,
  input  logic [DW-1:0]    host_crc,
  input  logic             word_valid,
  output logic             word_ready,
  input  logic [DW-1:0]    word_data,
  output logic             crc_err,
  output logic [CNT_W-1:0] err_burst,
  output logic [CNT_W-1:0] burst_num,
  output logic             cmd_busy,
  output logic             cmd_aborted,
  output logic             done_irq
);
  logic                  active;
  logic [DW-1:0]         crc_cur;
  logic                  first_err;
  bcc_pkg::burst_close_t close_s;

  bcc_crc_acc #(.DW(DW), .POLY(POLY[DW-1:0]), .SEED(SEED[DW-1:0])) u_acc (
    .clk(clk), .rst_n(rst_n),
    .open_i(burst_start), .close_i(burst_end),
    .wvalid_i(word_valid), .wdata_i(word_data), .wready_o(word_ready),
    .active_o(active), .crc_o(crc_cur)
  );

  assign close_s.ev       = active & burst_end;
  assign close_s.mismatch = (crc_cur != host_crc);

  bcc_err_latch #(.CNT_W(CNT_W)) u_err (
    .clk(clk), .rst_n(rst_n), .clear_i(cmd_start), .close_i(close_s),
    .first_err_o(first_err), .err_o(crc_err), .idx_o(err_burst), .cnt_o(burst_num)
  );

  bcc_cmd_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .start_i(cmd_start), .done_i(cmd_done),
    .abort_en_i(abort_on_err), .first_err_i(first_err),
    .busy_o(cmd_busy), .aborted_o(cmd_aborted), .irq_o(done_irq)
  );

  p_idle_end_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && !active && !cmd_start) |=> $stable(burst_num));
  p_ready_needs_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> (word_ready || burst_end));
endmodule

// File: tb/test_burst_crc_checker.sv
`timescale 1ns/100ps
module test_burst_crc_checker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, cmd_done = 0, abort_on_err = 0;
  logic burst_start = 0, burst_end = 0, word_valid = 0;
  logic [15:0] host_crc = '0, word_data = '0;
  logic word_ready, crc_err, cmd_busy, cmd_aborted, done_irq;
  logic [7:0] err_burst, burst_num;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  burst_crc_checker i_burst_crc_checker (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_done(cmd_done),
    .abort_on_err(abort_on_err), .burst_start(burst_start), .burst_end(burst_end),
    .host_crc(host_crc), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .crc_err(crc_err), .err_burst(err_burst),
    .burst_num(burst_num), .cmd_busy(cmd_busy), .cmd_aborted(cmd_aborted),
    .done_irq(done_irq)
  );

  function automatic int crc_step(int c, int d);
    int r = c;
    for (int b = 15; b >= 0; b--) begin
      int top = ((r >> 15) & 1) ^ ((d >> b) & 1);
      r = (r << 1) & 32'hFFFF;
      if (top != 0) r = r ^ 32'h1021;
    end
    return r;
  endfunction

  // behavioural reference model
  int m_active = 0, m_crc = 32'h4ABA, m_err = 0, m_idx = 0, m_cnt = 0;
  int m_busy = 0, m_abort = 0, m_irq = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_crc = 32'h4ABA; m_err = 0; m_idx = 0; m_cnt = 0;
      m_busy = 0; m_abort = 0; m_irq = 0;
    end else begin
      int endev, mism, first, take, abortev, fin;
      endev = (m_active != 0 && burst_end) ? 1 : 0;
      mism  = (m_crc != int'(host_crc)) ? 1 : 0;
      take  = (m_active != 0 && !burst_end && word_valid) ? 1 : 0;
      first = (endev != 0 && mism != 0 && m_err == 0 && !cmd_start) ? 1 : 0;
      abortev = (m_busy != 0 && first != 0 && abort_on_err) ? 1 : 0;
      fin = (m_busy != 0 && !cmd_start && (cmd_done || abortev != 0)) ? 1 : 0;
      if (cmd_start) begin
        m_err = 0; m_idx = 0; m_cnt = 0;
      end else if (endev != 0) begin
        if (first != 0) begin m_err = 1; m_idx = m_cnt; end
        m_cnt = (m_cnt + 1) & 255;
      end
      if (cmd_start) begin
        m_busy = 1; m_abort = 0; m_irq = 0;
      end else begin
        m_irq = fin;
        if (fin != 0) m_busy = 0;
        if (abortev != 0) m_abort = 1;
      end
      if (burst_start) m_crc = 32'h4ABA;
      else if (take != 0) m_crc = crc_step(m_crc, int'(word_data));
      if (burst_start) m_active = 1;
      else if (endev != 0) m_active = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2", "word_ready", int'(word_ready), (m_active != 0 && !burst_end) ? 1 : 0);
      chk("R4", "crc_err", int'(crc_err), m_err);
      chk("R5", "err_burst", int'(err_burst), m_idx);
      chk("R6", "burst_num", int'(burst_num), m_cnt);
      chk("R7", "cmd_aborted", int'(cmd_aborted), m_abort);
      chk("R9", "cmd_busy", int'(cmd_busy), m_busy);
      chk("R8", "done_irq", int'(done_irq), m_irq);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic start_cmd(input bit pol);
    step(); cmd_start = 1; abort_on_err = pol;
    step(); cmd_start = 0;
  endtask

  task automatic finish_cmd();
    step(); cmd_done = 1;
    step(); cmd_done = 0;
  endtask

  task automatic burst(input int n, input bit corrupt, input bit stray);
    int c = 32'h4ABA;
    step(); burst_start = 1; word_valid = stray; word_data = 16'hDEAD;
    for (int k = 0; k < n; k++) begin
      logic [15:0] w = 16'($urandom);
      step(); burst_start = 0; word_valid = 1; word_data = w;
      c = crc_step(c, int'(w));
    end
    step(); burst_start = 0; word_valid = stray; word_data = 16'hBEEF; burst_end = 1;
    host_crc = corrupt ? (16'(c) ^ 16'h0100) : 16'(c);
    step(); burst_end = 0; word_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    step();
    // R1 reset state
    chk("R1", "ready after reset", int'(word_ready), 0);
    chk("R1", "err after reset", int'(crc_err), 0);
    chk("R1", "busy/abort/irq after reset", int'({cmd_busy, cmd_aborted, done_irq}), 0);
    chk("R1", "counters after reset", int'({err_burst, burst_num}), 0);

    // R3 good burst, R6 count, R8 irq
    start_cmd(0);
    burst(4, 0, 0);
    chk("R3", "matching crc no error", int'(crc_err), 0);
    chk("R6", "one burst counted", int'(burst_num), 1);
    step(); cmd_done = 1; step(); cmd_done = 0;
    chk("R8", "irq after done", int'(done_irq), 1);
    step();
    chk("R8", "irq one cycle", int'(done_irq), 0);

    // R4/R5 first error kept across bursts, policy off
    start_cmd(0);
    burst(3, 0, 0);
    burst(2, 1, 0);
    chk("R4", "mismatch sets error", int'(crc_err), 1);
    chk("R5", "first failing index", int'(err_burst), 1);
    burst(5, 1, 0);
    chk("R5", "later error keeps index", int'(err_burst), 1);
    burst(1, 0, 0);
    chk("R5", "good burst keeps error", int'(crc_err), 1);
    chk("R6", "four bursts counted", int'(burst_num), 4);
    chk("R7", "no abort with policy off", int'(cmd_aborted), 0);
    chk("R7", "still busy with policy off", int'(cmd_busy), 1);
    finish_cmd();

    // R9 clear on new command
    start_cmd(1);
    chk("R9", "error cleared", int'(crc_err), 0);
    chk("R9", "counters cleared", int'({err_burst, burst_num}), 0);

    // R7 abort policy
    burst(2, 1, 0);
    chk("R7", "aborted on first error", int'(cmd_aborted), 1);
    chk("R7", "irq on abort", int'(done_irq), 1);
    chk("R7", "busy cleared by abort", int'(cmd_busy), 0);
    finish_cmd();
    chk("R8", "done while idle gives no irq", int'(done_irq), 0);

    // R2 stray words while not ready
    start_cmd(0);
    burst(5, 0, 1);
    chk("R2", "stray words ignored", int'(crc_err), 0);

    // R10 idle burst_end
    step(); burst_end = 1; host_crc = 16'h1234;
    step(); burst_end = 0;
    chk("R10", "idle end leaves count", int'(burst_num), 1);
    chk("R10", "idle end leaves error", int'(crc_err), 0);
    finish_cmd();

    // random commands
    for (int t = 0; t < 40; t++) begin
      start_cmd(1'($urandom));
      for (int b = 0; b < 1 + int'($urandom % 4); b++)
        burst(int'($urandom % 6), ($urandom % 3) == 0, 1'($urandom));
      finish_cmd();
    end
    repeat (3) step();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule